// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-side engine of a byte-wide serial memory that is reached over a two-wire (I2C-style) bus. It runs on a fast system clock. It oversamples the clock and data lines through synchronizers and pulls the data line low through an open-drain enable. It finds start and stop conditions. It takes in a header byte that carries a fixed identity nibble, two bits that must be zero, the top address bit and a read/write flag. It acknowledges each byte it accepts. A write transfer then brings two address bytes followed by data bytes, and each data byte goes to the memory port as a one-cycle write strobe. A read transfer shifts bytes out most significant bit first. These bytes are taken from a persistent address counter, and reading continues for as long as the master acknowledges.

A write-cycle controller outside the block reports through `busy_in` that a nonvolatile write is still in progress. While it is high, header bytes are left unacknowledged, which lets a master poll for completion.

The controller has these states: `ST_IDLE` (bus free), `ST_DEV` (header shifting in), `ST_DEV_ACK`, `ST_ADDR_HI`, `ST_HI_ACK`, `ST_ADDR_LO`, `ST_LO_ACK`, `ST_WDATA`, `ST_WD_ACK`, `ST_RDATA` (byte shifting out), `ST_MACK` (master's acknowledge slot) and `ST_IGNORE` (deaf until the next start).

Its transitions are:
- A start from any state goes to `ST_DEV`.
- A stop from any state goes to `ST_IDLE`.
- In `ST_DEV`, the end of the byte goes to `ST_DEV_ACK` when the header matches and the block is not busy, and to `ST_IGNORE` otherwise.
- From `ST_DEV_ACK`, a falling clock goes to `ST_RDATA` for a read and to `ST_ADDR_HI` for a write.
- From `ST_ADDR_HI`, `ST_ADDR_LO` and `ST_WDATA`, the end of the byte goes to the matching acknowledge state.
- Each of those acknowledge states goes on to the next byte state: `ST_ADDR_LO`, `ST_WDATA`, and `ST_WDATA` again.
- From `ST_RDATA`, the end of the byte goes to `ST_MACK`.
- From `ST_MACK`, a falling clock goes back to `ST_RDATA` if the master acknowledged and to `ST_IGNORE` if it did not.

Top module: `twsm_slave`

## Requirements
- R1: A falling SDA while SCL is high (start) begins reception of a new header from any state, and it also aborts a byte that is half shifted in. A rising SDA while SCL is high (stop) returns the block to idle with SDA released, and it also aborts a partial data byte, which is then never written.
- R2: Header bits are taken MSB first on SCL rising edges in the format 1,0,1,0,0,0,P,RW. A matching header is acknowledged by holding SDA low through the ninth SCL high phase.
- R3: A header with the wrong identity nibble, or with either of its two zero bits set, gets no acknowledge. Bytes that follow it, up to the next start, get no acknowledge and cause no write.
- R4: While `busy_in` is high, a header is left unacknowledged. Once `busy_in` is low, the same header is acknowledged.
- R5: After a write header (RW=0), the high address byte and then the low address byte are each acknowledged. The address becomes {P, high, low}.
- R6: Each data byte after the address gives one single-cycle `mem_we` pulse, with `mem_addr` equal to the target address and `mem_wdata` equal to the received byte. The byte is acknowledged.
- R7: Successive write bytes in one transfer advance only address bits 7:0, so an address ending in FF is followed by the same upper bits with low byte 00.
- R8: A read header (RW=1) is followed by the byte at the address counter, driven MSB first. SDA changes only while SCL is low.
- R9: The address counter holds the last accessed address plus one and keeps that value across transfers. A header, two address bytes, a repeated start and a read header together return the byte at the loaded address.
- R10: In a read, each master acknowledge (SDA low in the ninth slot) brings the next byte. A master non-acknowledge leaves SDA released until the next start or stop.
- R11: During reads the counter wraps from 1FFFF to 00000.
- R12: After reset, `sda_oe` and `mem_we` are 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| mem_addr | output | ADDR_W | Memory address: the read address, or the write address while `mem_we` is high |
| mem_rdata | input | 8 | Byte at `mem_addr`, valid in the same cycle |
| mem_wdata | output | 8 | Byte to be written |
| mem_we | output | 1 | One-cycle write strobe |
| busy_in | input | 1 | Write cycle in progress; headers are not acknowledged |

## Verification
A start can arrive in the same clock window as a byte that is only half shifted, so the abort of the old frame and the opening of a new header happen on one edge. The bench provokes this with a repeated start after four header bits. It judges the result by the acknowledge of the header that follows and by the data returned from the counter. The same applies to a stop that lands inside a data byte: the bench issues a stop three bits into a data byte and checks that no write strobe appears. It then checks that a current read returns the byte at the address that was already loaded.

// File: rtl/twsm_pkg.sv
package twsm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR_HI,
        ST_HI_ACK,
        ST_ADDR_LO,
        ST_LO_ACK,
        ST_WDATA,
        ST_WD_ACK,
        ST_RDATA,
        ST_MACK,
        ST_IGNORE
    } twsm_state_e;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;

endpackage

// File: rtl/twsm_sync.sv
// Multi-stage synchronizer for one bus line; also exposes the previous
// synchronized value so the caller can find edges.
module twsm_sync #(
    parameter int N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic prv
);
    logic [N:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[N-1:0], din};
    end

    assign lvl = chain[N-1];
    assign prv = chain[N];
endmodule

// File: rtl/twsm_shift.sv
// Shared byte shifter: samples the line on every SCL rise (receive) and
// exposes its MSB as the next bit to drive (transmit).
module twsm_shift #(
    parameter int W     = 8,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             smp,
    input  logic             din,
    input  logic             ld,
    input  logic [W-1:0]     ld_val,
    output logic [W-1:0]     sh,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   sh <= '0;
        else if (ld)  sh <= ld_val;
        else if (smp) sh <= {sh[W-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (smp) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/twsm_actr.sv
// Address counter: full-width increment for reads, low-field increment
// (page wrap) for writes, parallel load from the address bytes.
module twsm_actr #(
    parameter int ADDR_W = 17,
    parameter int PAGE   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_val,
    input  logic              inc_all,
    input  logic              inc_page,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (ld)       q <= ld_val;
        else if (inc_all)  q <= q + 1'b1;
        else if (inc_page) q <= {q[ADDR_W-1:PAGE], q[PAGE-1:0] + 1'b1};
    end
endmodule

// File: rtl/twsm_slave.sv
module twsm_slave
    import twsm_pkg::*;
#(
    parameter int         ADDR_W = 17,
    parameter logic [3:0] DEV_ID = 4'hA,
    parameter int         SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic              busy_in
);
    localparam int         PG_W  = ADDR_W - 16;
    localparam logic [2:0] ZMASK = 3'(7 << PG_W);
    localparam int         PAGE  = 8;

    // ---------------- line synchronizers ----------------
    logic [1:0] raw, lvl, prv;
    assign raw = {scl_in, sda_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        twsm_sync #(.N(SYNC_N)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .lvl  (lvl[g]),
            .prv  (prv[g])
        );
    end

    logic scl_l, scl_p, sda_l, sda_p;
    logic scl_r, scl_f, start_c, stop_c;
    assign scl_l   = lvl[1];
    assign scl_p   = prv[1];
    assign sda_l   = lvl[0];
    assign sda_p   = prv[0];
    assign scl_r   = scl_l & ~scl_p;
    assign scl_f   = ~scl_l & scl_p;
    assign start_c = scl_l & scl_p & sda_p & ~sda_l;
    assign stop_c  = scl_l & scl_p & ~sda_p & sda_l;

    // ---------------- datapath ----------------
    twsm_state_e        st, nxt;
    logic               clr_cnt, ld_sh, inc_all, ctr_ld;
    logic [BYTE_W-1:0]  sh;
    logic [CNT_W-1:0]   cnt;
    logic [ADDR_W-1:0]  ctr;
    logic               hdr_rw;
    logic [PG_W-1:0]    hdr_pg;
    logic [7:0]         hi_q;

    twsm_shift #(.W(BYTE_W), .CNT_W(CNT_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_cnt),
        .smp   (scl_r),
        .din   (sda_l),
        .ld    (ld_sh),
        .ld_val(mem_rdata),
        .sh    (sh),
        .cnt   (cnt)
    );

    twsm_actr #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_actr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (ctr_ld),
        .ld_val  ({hdr_pg, hi_q, sh}),
        .inc_all (inc_all),
        .inc_page(mem_we),
        .q       (ctr)
    );

    assign mem_addr = ctr;

    logic byte_done, dev_ok, mack_ok, last_bit;
    assign last_bit  = (cnt == CNT_W'(BYTE_W));
    assign byte_done = scl_f & last_bit;
    assign dev_ok    = (sh[7:4] == DEV_ID) && ((sh[3:1] & ZMASK) == 3'b000) && !busy_in;
    assign mack_ok   = ~sh[0];

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // ---------------- next state and datapath controls ----------------
    always_comb begin
        nxt     = st;
        clr_cnt = 1'b0;
        ld_sh   = 1'b0;
        inc_all = 1'b0;
        ctr_ld  = 1'b0;
        if (start_c) begin
            nxt     = ST_DEV;
            clr_cnt = 1'b1;
        end else if (stop_c) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE, ST_IGNORE: nxt = st;
                ST_DEV: begin
                    if (byte_done) nxt = dev_ok ? ST_DEV_ACK : ST_IGNORE;
                end
                ST_DEV_ACK: begin
                    if (scl_f) begin
                        clr_cnt = 1'b1;
                        if (hdr_rw) begin
                            nxt     = ST_RDATA;
                            ld_sh   = 1'b1;
                            inc_all = 1'b1;
                        end else begin
                            nxt = ST_ADDR_HI;
                        end
                    end
                end
                ST_ADDR_HI: if (byte_done) nxt = ST_HI_ACK;
                ST_HI_ACK: begin
                    if (scl_f) begin
                        nxt     = ST_ADDR_LO;
                        clr_cnt = 1'b1;
                    end
                end
                ST_ADDR_LO: begin
                    if (byte_done) begin
                        nxt    = ST_LO_ACK;
                        ctr_ld = 1'b1;
                    end
                end
                ST_LO_ACK, ST_WD_ACK: begin
                    if (scl_f) begin
                        nxt     = ST_WDATA;
                        clr_cnt = 1'b1;
                    end
                end
                ST_WDATA: if (byte_done) nxt = ST_WD_ACK;
                ST_RDATA: if (byte_done) nxt = ST_MACK;
                ST_MACK: begin
                    if (scl_f) begin
                        if (mack_ok) begin
                            nxt     = ST_RDATA;
                            clr_cnt = 1'b1;
                            ld_sh   = 1'b1;
                            inc_all = 1'b1;
                        end else begin
                            nxt = ST_IGNORE;
                        end
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            hdr_rw    <= 1'b0;
            hdr_pg    <= '0;
            hi_q      <= '0;
        end else begin
            mem_we <= 1'b0;
            if (start_c || stop_c) begin
                sda_oe <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEV: begin
                        if (byte_done) begin
                            hdr_rw <= sh[0];
                            hdr_pg <= sh[PG_W:1];
                            sda_oe <= dev_ok;
                        end
                    end
                    ST_ADDR_HI: begin
                        if (byte_done) begin
                            hi_q   <= sh;
                            sda_oe <= 1'b1;
                        end
                    end
                    ST_ADDR_LO: if (byte_done) sda_oe <= 1'b1;
                    ST_WDATA: begin
                        if (byte_done) begin
                            sda_oe    <= 1'b1;
                            mem_we    <= 1'b1;
                            mem_wdata <= sh;
                        end
                    end
                    ST_DEV_ACK: if (scl_f) sda_oe <= hdr_rw ? ~mem_rdata[7] : 1'b0;
                    ST_HI_ACK, ST_LO_ACK, ST_WD_ACK: if (scl_f) sda_oe <= 1'b0;
                    ST_RDATA: if (scl_f) sda_oe <= last_bit ? 1'b0 : ~sh[7];
                    ST_MACK: if (scl_f) sda_oe <= mack_ok ? ~mem_rdata[7] : 1'b0;
                    default: sda_oe <= 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/twsm_chk.sv
module twsm_chk
    import twsm_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_l,
    input logic              start_c,
    input logic              stop_c,
    input logic              sda_oe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input twsm_state_e       st
);
    // R1: a start always opens a new header
    a_r1_start_enters_dev: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (st == ST_DEV));

    // R1: a stop returns to idle with the line released
    a_r1_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (st == ST_IDLE && !sda_oe));

    // R8: the data line is only changed while SCL is low (or on a bus condition)
    a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_l || $past(start_c || stop_c)));

    // R6: the write strobe lasts one cycle
    a_r6_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R7: a write advances only the low address byte
    a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr[7:0] == $past(mem_addr[7:0]) + 8'd1 &&
                    mem_addr[ADDR_W-1:8] == $past(mem_addr[ADDR_W-1:8])));
endmodule

bind twsm_slave twsm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_l   (scl_l),
    .start_c (start_c),
    .stop_c  (stop_c),
    .sda_oe  (sda_oe),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .st      (st)
);

// File: tb/tb_twsm_slave.sv
module tb_twsm_slave;
    localparam int CLK_P = 10;
    localparam int HP    = 8;
    localparam int WD    = 150000;

    typedef struct packed {
        logic [16:0] a;
        logic [7:0]  d;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{17'h00000, 8'h3C}, '{17'h0ABCD, 8'hA5}, '{17'h10000, 8'h01},
        '{17'h1FFFF, 8'hFE}, '{17'h155AA, 8'h7E}, '{17'h0FFFF, 8'h80}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_m = 1'b1;
    logic        busy = 1'b0;
    logic        sda_oe;
    logic [16:0] mem_addr;
    logic [7:0]  mem_rdata, mem_wdata;
    logic        mem_we;
    wire         sda_w = sda_m & ~sda_oe;

    int          nchk = 0, nfail = 0, wcount = 0;
    logic [16:0] wlog_a = '0;
    logic [7:0]  wlog_d = '0;
    logic        done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    twsm_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_w),
        .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .busy_in(busy)
    );

    function automatic logic [7:0] fmem(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ {a[16], 7'h35};
    endfunction

    always_comb mem_rdata = fmem(mem_addr);

    always @(posedge clk) begin
        if (mem_we) begin
            wcount <= wcount + 1;
            wlog_a <= mem_addr;
            wlog_d <= mem_wdata;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(HP/2);
        scl = 1'b1;   tick(HP/2);
        sda_m = 1'b0; tick(HP/2);
        scl = 1'b0;   tick(HP/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP/2);
        scl = 1'b1;   tick(HP/2);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic clk_bit(input logic b, output logic s);
        sda_m = b;  tick(HP/2);
        scl = 1'b1; tick(HP/2);
        s = sda_w;  tick(HP/2);
        scl = 1'b0; tick(HP/2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic s;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            clk_bit(1'b1, s);
            d = {d[6:0], s};
        end
        clk_bit(~give_ack, s);
    endtask

    function automatic logic [7:0] hdr(input logic [16:0] a, input logic rd);
        return {4'hA, 2'b00, a[16], rd};
    endfunction

    // header plus two address bytes; returns AND of acks
    task automatic addr_phase(input logic [16:0] a, output logic ok);
        logic k1, k2, k3;
        bus_start();
        send_byte(hdr(a, 1'b0), k1);
        send_byte(a[15:8], k2);
        send_byte(a[7:0], k3);
        ok = k1 & k2 & k3;
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired act=running exp=done");
            summary();
            $finish;
        end
    end

    initial begin
        logic        ok, ack;
        logic [7:0]  d;
        int          wc0;

        tick(5);
        // R12: reset state
        chk("R12 sda_oe", sda_oe, 0);
        chk("R12 mem_we", mem_we, 0);
        chk("R12 mem_addr", mem_addr, 0);
        rst_n = 1'b1;
        tick(4);

        // R8: current read right after reset
        bus_start();
        send_byte(8'hA1, ack);
        chk("R2 read header ack", ack, 1);
        recv_byte(1'b0, d);
        chk("R8 current read data", d, fmem(17'h0));
        bus_stop();
        chk("R9 counter after read", mem_addr, 17'h1);

        // vector table: write then random read at each address
        for (int i = 0; i < 6; i++) begin
            wc0 = wcount;
            addr_phase(VEC[i].a, ok);
            send_byte(VEC[i].d, ack);
            bus_stop();
            chk("R5 address byte acks", ok & ack, 1);
            chk("R6 one write strobe", wcount, wc0 + 1);
            chk("R6 write address", wlog_a, VEC[i].a);
            chk("R6 write data", wlog_d, VEC[i].d);
            addr_phase(VEC[i].a, ok);
            bus_start();
            send_byte(hdr(VEC[i].a, 1'b1), ack);
            recv_byte(1'b0, d);
            bus_stop();
            chk("R9 random read data", d, fmem(VEC[i].a));
            chk("R11 counter after random read", mem_addr, 17'(VEC[i].a + 17'd1));
        end

        // R3: wrong identity, then traffic without start is ignored
        wc0 = wcount;
        bus_start();
        send_byte(8'hB0, ack);
        chk("R3 wrong id nack", ack, 0);
        send_byte(8'hA0, ack);
        chk("R3 ignored follow byte", ack, 0);
        send_byte(8'h55, ack);
        bus_stop();
        chk("R3 no write", wcount, wc0);

        // R2/R3: a zero bit set in the header
        bus_start();
        send_byte(8'hA4, ack);
        bus_stop();
        chk("R3 zero bit set nack", ack, 0);

        // R4: busy suppresses the header acknowledge
        busy = 1'b1;
        bus_start();
        send_byte(8'hA1, ack);
        bus_stop();
        chk("R4 busy nack", ack, 0);
        busy = 1'b0;
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R4 ack after busy", ack, 1);

        // R7: page wrap on writes
        addr_phase(17'h112FE, ok);
        chk("R5 acks page test", ok, 1);
        send_byte(8'h11, ack);
        chk("R7 first write addr", wlog_a, 17'h112FE);
        send_byte(8'h22, ack);
        chk("R7 second write addr", wlog_a, 17'h112FF);
        send_byte(8'h33, ack);
        chk("R7 wrapped write addr", wlog_a, 17'h11200);
        chk("R7 wrapped write data", wlog_d, 8'h33);
        bus_stop();
        chk("R7 counter after page", mem_addr, 17'h11201);

        // R10/R11: sequential read across the array end
        addr_phase(17'h1FFFE, ok);
        bus_start();
        send_byte(8'hA3, ack);
        recv_byte(1'b1, d);
        chk("R10 seq byte 0", d, fmem(17'h1FFFE));
        recv_byte(1'b1, d);
        chk("R10 seq byte 1", d, fmem(17'h1FFFF));
        recv_byte(1'b0, d);
        chk("R11 seq byte wrapped", d, fmem(17'h00000));
        tick(HP);
        chk("R10 released after nack", sda_oe, 0);
        bus_stop();
        chk("R9 counter after seq", mem_addr, 17'h1);

        // R1: repeated start in the middle of a header
        bus_start();
        clk_bit(1'b1, ack); clk_bit(1'b0, ack);
        clk_bit(1'b1, ack); clk_bit(1'b0, ack);
        bus_start();
        send_byte(8'hA1, ack);
        chk("R1 header after abort ack", ack, 1);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R1 data after abort", d, fmem(17'h1));

        // R1: stop inside a data byte writes nothing, address stays loaded
        wc0 = wcount;
        addr_phase(17'h00777, ok);
        clk_bit(1'b0, ack); clk_bit(1'b1, ack); clk_bit(1'b1, ack);
        bus_stop();
        chk("R1 stop mid byte no write", wcount, wc0);
        bus_start();
        send_byte(8'hA1, ack);
        recv_byte(1'b0, d);
        bus_stop();
        chk("R1 read after aborted write", d, fmem(17'h00777));

        done = 1'b1;
        summary();
        $finish;
    end
endmodule